// File: doc/BRIEF.md
# Context Resource Allocation Command Unit

This block is the configuration handle through which software binds hardware resources to one execution context. Software presents three things. The first is a 32-bit map of data-segment units, one bit per 1 KB of a 32 KB store. The second is a 64-bit map of control-block pairs. The third is eight address-space IDs, each with a 16-bit page-size availability mask. It then pulses a command strobe with one of five opcodes.

The unit accepts the command and reports itself active for a fixed number of cycles. At the end of that window it judges the request against two things: the current context state, and the ownership vectors that the other contexts already hold. It then either moves the context to its next state or reports an exception with an encoded cause, leaving the state alone. On a successful allocate, the maps and the address-space slots are committed to outputs that the rest of the chip uses. A successful deallocate releases both maps.

Top module: `ctx_cfg_unit`

## Requirements
- R1: After reset the state is inactive (0), status is idle (0), cause is 0 and both owned maps are zero.
- R2: When `cmd_go` is sampled while status is not active, status reads active (2) for exactly OP_LAT cycles and then shows the result.
- R3: Allocate (opcode 2) from inactive with a nonzero, non-conflicting control-block map moves the state to mapped (1). The owned maps then equal the requested maps, and each address-space and page-size slot equals its requested value.
- R4: Start (1) from mapped or interrupted moves to active (2). Interrupt (3) and interrupt-sync (5) from active move to interrupted (3). Deallocate (4) from mapped or interrupted moves to inactive and clears both owned maps.
- R5: An opcode that is valid but used from a wrong state ends in exception (status 1) with the state unchanged. The cause is 3 for start, 4 for allocate, 5 for deallocate, and 6 for interrupt or interrupt-sync.
- R6: Opcodes 0, 6 and 7 end in exception with cause 2 (illegal opcode).
- R7: An allocate from inactive with an all-zero control-block map gives cause 8. This takes precedence over the conflict checks.
- R8: An allocate whose control-block map overlaps the peer-owned control-block vector gives cause 10. Failing that, an overlap of the data-segment map with the peer data-segment vector gives cause 11. In both cases nothing is committed.
- R9: A `cmd_go` while status is active is not started as a new command. The operation in flight still takes its state effect, but it finishes with status exception and cause 7 (busy).
- R10: Any completion with status idle carries cause 0. After an exception, the next successful command returns status to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Command strobe |
| cmd_opc | input | 3 | Opcode |
| req_dsr_map | input | 32 | Requested data-segment unit map |
| req_cbr_map | input | 64 | Requested control-block pair map |
| req_asid | input | 256 | Eight 32-bit address-space IDs, slot 0 in the low bits |
| req_sizeavail | input | 128 | Eight 16-bit page-size masks, slot 0 in the low bits |
| peer_dsr_own | input | 32 | Data-segment units owned by other contexts |
| peer_cbr_own | input | 64 | Control-block pairs owned by other contexts |
| hs_status | output | 2 | 0 idle, 1 exception, 2 active |
| hs_state | output | 2 | 0 inactive, 1 mapped, 2 active, 3 interrupted |
| hs_cause | output | 4 | Exception cause code |
| own_dsr_map | output | 32 | Data-segment units held by this context |
| own_cbr_map | output | 64 | Control-block pairs held by this context |
| ctx_asid | output | 256 | Committed address-space IDs |
| ctx_sizeavail | output | 128 | Committed page-size masks |

## Verification
A wrong context state stays hidden until the next command completes. It then shows up as a cause code for a wrong transition (3 to 6) where success was expected, or as success where an exception was expected. That happens OP_LAT cycles after the strobe. Wrong ownership shows at once on the owned-map outputs after an allocate or deallocate completes. It can also show later as a missed or spurious cause 10 or 11. A fault in the completion counter or the busy flag shows as a wrong active span, or as a missing cause 7 on the very completion that follows the overlapping strobe.

// File: rtl/ccfg_pkg.sv
package ccfg_pkg;

    localparam int DSR_UNITS = 32;
    localparam int CBR_PAIRS = 64;
    localparam int NUM_SLOTS = 8;
    localparam int ASID_W    = 32;
    localparam int SZ_W      = 16;

    localparam logic [2:0] OPC_START     = 3'd1;
    localparam logic [2:0] OPC_ALLOC     = 3'd2;
    localparam logic [2:0] OPC_INTR      = 3'd3;
    localparam logic [2:0] OPC_DEALLOC   = 3'd4;
    localparam logic [2:0] OPC_INTR_SYNC = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXC  = 2'd1,
        ST_ACT  = 2'd2
    } hs_status_e;

    typedef enum logic [1:0] {
        CX_INACTIVE = 2'd0,
        CX_MAPPED   = 2'd1,
        CX_ACTIVE   = 2'd2,
        CX_INTR     = 2'd3
    } ctx_state_e;

    typedef enum logic [3:0] {
        CS_NONE       = 4'd0,
        CS_RR_WRITE   = 4'd1,
        CS_BAD_OPC    = 4'd2,
        CS_BAD_START  = 4'd3,
        CS_BAD_ALLOC  = 4'd4,
        CS_BAD_DEALL  = 4'd5,
        CS_BAD_INTR   = 4'd6,
        CS_BUSY       = 4'd7,
        CS_NO_CBR     = 4'd8,
        CS_FMAP_CFG   = 4'd9,
        CS_CBR_OVER   = 4'd10,
        CS_DSR_OVER   = 4'd11,
        CS_CBR_DEALL  = 4'd12
    } cause_e;

    typedef struct packed {
        logic       ok;
        cause_e     cause;
        ctx_state_e next;
    } verdict_t;

    function automatic verdict_t judge(
        input logic [2:0]           opc,
        input ctx_state_e           cur,
        input logic [DSR_UNITS-1:0] dsr,
        input logic [CBR_PAIRS-1:0] cbr,
        input logic [DSR_UNITS-1:0] peer_dsr,
        input logic [CBR_PAIRS-1:0] peer_cbr
    );
        verdict_t v;
        v.ok    = 1'b0;
        v.cause = CS_NONE;
        v.next  = cur;
        case (opc)
            OPC_START: begin
                if (cur == CX_MAPPED || cur == CX_INTR) begin
                    v.ok = 1'b1; v.next = CX_ACTIVE;
                end else v.cause = CS_BAD_START;
            end
            OPC_ALLOC: begin
                if (cur != CX_INACTIVE)         v.cause = CS_BAD_ALLOC;
                else if (cbr == '0)             v.cause = CS_NO_CBR;
                else if ((cbr & peer_cbr) != 0) v.cause = CS_CBR_OVER;
                else if ((dsr & peer_dsr) != 0) v.cause = CS_DSR_OVER;
                else begin
                    v.ok = 1'b1; v.next = CX_MAPPED;
                end
            end
            OPC_INTR, OPC_INTR_SYNC: begin
                if (cur == CX_ACTIVE) begin
                    v.ok = 1'b1; v.next = CX_INTR;
                end else v.cause = CS_BAD_INTR;
            end
            OPC_DEALLOC: begin
                if (cur == CX_MAPPED || cur == CX_INTR) begin
                    v.ok = 1'b1; v.next = CX_INACTIVE;
                end else v.cause = CS_BAD_DEALL;
            end
            default: v.cause = CS_BAD_OPC;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ccfg_check.sv
module ccfg_check
    import ccfg_pkg::*;
(
    input  logic [2:0]           opc,
    input  ctx_state_e           cur,
    input  logic [DSR_UNITS-1:0] dsr,
    input  logic [CBR_PAIRS-1:0] cbr,
    input  logic [DSR_UNITS-1:0] peer_dsr,
    input  logic [CBR_PAIRS-1:0] peer_cbr,
    output verdict_t             verdict
);
    always_comb verdict = judge(opc, cur, dsr, cbr, peer_dsr, peer_cbr);
endmodule

// File: rtl/ccfg_seq.sv
module ccfg_seq
    import ccfg_pkg::*;
#(
    parameter int OP_LAT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_go,
    input  verdict_t   verdict,
    output logic       accept,
    output logic       done,
    output hs_status_e status,
    output cause_e     cause
);
    localparam int CW = $clog2(OP_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(OP_LAT - 1);

    logic [CW-1:0] cnt;
    logic          busy_seen;
    logic          busy_now;

    assign accept   = cmd_go && (status != ST_ACT);
    assign done     = (status == ST_ACT) && (cnt == '0);
    assign busy_now = busy_seen || cmd_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= ST_IDLE;
            cause     <= CS_NONE;
            cnt       <= '0;
            busy_seen <= 1'b0;
        end else if (status == ST_ACT) begin
            if (cnt == '0) begin
                busy_seen <= 1'b0;
                if (busy_now) begin
                    status <= ST_EXC;
                    cause  <= CS_BUSY;
                end else if (verdict.ok) begin
                    status <= ST_IDLE;
                    cause  <= CS_NONE;
                end else begin
                    status <= ST_EXC;
                    cause  <= verdict.cause;
                end
            end else begin
                cnt <= cnt - 1'b1;
                if (cmd_go) busy_seen <= 1'b1;
            end
        end else if (cmd_go) begin
            status    <= ST_ACT;
            cnt       <= LAST;
            busy_seen <= 1'b0;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                                    // R2
    AST_STATUS_ENC: assert property (@(posedge clk) disable iff (rst)
        status != 2'd3);                                                 // R2
    AST_IDLE_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        status == ST_IDLE |-> cause == CS_NONE);                         // R10
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        accept |=> status == ST_ACT);                                    // R2
endmodule

// File: rtl/ccfg_store.sv
module ccfg_store
    import ccfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        commit,
    input  logic                        release_all,
    input  logic [DSR_UNITS-1:0]        dsr_in,
    input  logic [CBR_PAIRS-1:0]        cbr_in,
    input  logic [NUM_SLOTS*ASID_W-1:0] asid_in,
    input  logic [NUM_SLOTS*SZ_W-1:0]   size_in,
    output logic [DSR_UNITS-1:0]        dsr_own,
    output logic [CBR_PAIRS-1:0]        cbr_own,
    output logic [NUM_SLOTS*ASID_W-1:0] asid_out,
    output logic [NUM_SLOTS*SZ_W-1:0]   size_out
);
    always_ff @(posedge clk) begin
        if (rst || release_all) begin
            dsr_own <= '0;
            cbr_own <= '0;
        end else if (commit) begin
            dsr_own <= dsr_in;
            cbr_own <= cbr_in;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [ASID_W-1:0] asid_q;
        logic [SZ_W-1:0]   size_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                asid_q <= '0;
                size_q <= '0;
            end else if (commit) begin
                asid_q <= asid_in[g*ASID_W +: ASID_W];
                size_q <= size_in[g*SZ_W +: SZ_W];
            end
        end
        assign asid_out[g*ASID_W +: ASID_W] = asid_q;
        assign size_out[g*SZ_W +: SZ_W]     = size_q;
    end
endmodule

// File: rtl/ctx_cfg_unit.sv
module ctx_cfg_unit
    import ccfg_pkg::*;
#(
    parameter int OP_LAT = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_go,
    input  logic [2:0]                  cmd_opc,
    input  logic [DSR_UNITS-1:0]        req_dsr_map,
    input  logic [CBR_PAIRS-1:0]        req_cbr_map,
    input  logic [NUM_SLOTS*ASID_W-1:0] req_asid,
    input  logic [NUM_SLOTS*SZ_W-1:0]   req_sizeavail,
    input  logic [DSR_UNITS-1:0]        peer_dsr_own,
    input  logic [CBR_PAIRS-1:0]        peer_cbr_own,
    output logic [1:0]                  hs_status,
    output logic [1:0]                  hs_state,
    output logic [3:0]                  hs_cause,
    output logic [DSR_UNITS-1:0]        own_dsr_map,
    output logic [CBR_PAIRS-1:0]        own_cbr_map,
    output logic [NUM_SLOTS*ASID_W-1:0] ctx_asid,
    output logic [NUM_SLOTS*SZ_W-1:0]   ctx_sizeavail
);
    logic [2:0]                  p_opc;
    logic [DSR_UNITS-1:0]        p_dsr;
    logic [CBR_PAIRS-1:0]        p_cbr;
    logic [NUM_SLOTS*ASID_W-1:0] p_asid;
    logic [NUM_SLOTS*SZ_W-1:0]   p_size;

    ctx_state_e state;
    verdict_t   verdict;
    logic       accept, done, apply;
    hs_status_e status;
    cause_e     cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_opc  <= '0;
            p_dsr  <= '0;
            p_cbr  <= '0;
            p_asid <= '0;
            p_size <= '0;
        end else if (accept) begin
            p_opc  <= cmd_opc;
            p_dsr  <= req_dsr_map;
            p_cbr  <= req_cbr_map;
            p_asid <= req_asid;
            p_size <= req_sizeavail;
        end
    end

    ccfg_check u_check (
        .opc      (p_opc),
        .cur      (state),
        .dsr      (p_dsr),
        .cbr      (p_cbr),
        .peer_dsr (peer_dsr_own),
        .peer_cbr (peer_cbr_own),
        .verdict  (verdict)
    );

    ccfg_seq #(.OP_LAT(OP_LAT)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cmd_go  (cmd_go),
        .verdict (verdict),
        .accept  (accept),
        .done    (done),
        .status  (status),
        .cause   (cause)
    );

    assign apply = done && verdict.ok;

    always_ff @(posedge clk) begin
        if (rst)        state <= CX_INACTIVE;
        else if (apply) state <= verdict.next;
    end

    ccfg_store u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (apply && p_opc == OPC_ALLOC),
        .release_all (apply && p_opc == OPC_DEALLOC),
        .dsr_in      (p_dsr),
        .cbr_in      (p_cbr),
        .asid_in     (p_asid),
        .size_in     (p_size),
        .dsr_own     (own_dsr_map),
        .cbr_own     (own_cbr_map),
        .asid_out    (ctx_asid),
        .size_out    (ctx_sizeavail)
    );

    assign hs_status = status;
    assign hs_state  = state;
    assign hs_cause  = cause;

    AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(status) == ST_ACT && status == ST_EXC && cause != CS_BUSY
        |-> state == $past(state));                                      // R5
    AST_INACTIVE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        state == CX_INACTIVE |-> own_cbr_map == '0 && own_dsr_map == '0); // R4
    AST_HELD_CBR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != CX_INACTIVE |-> own_cbr_map != '0);                     // R7
    AST_STATE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        state != $past(state) |-> $past(status) == ST_ACT);              // R2
endmodule

// File: tb/ctx_cfg_unit_tb_top.sv
module ctx_cfg_unit_tb_top;
    localparam int OP_LAT = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_go;
    logic [2:0]   cmd_opc;
    logic [31:0]  req_dsr_map;
    logic [63:0]  req_cbr_map;
    logic [255:0] req_asid;
    logic [127:0] req_sizeavail;
    logic [31:0]  peer_dsr_own;
    logic [63:0]  peer_cbr_own;
    logic [1:0]   hs_status, hs_state;
    logic [3:0]   hs_cause;
    logic [31:0]  own_dsr_map;
    logic [63:0]  own_cbr_map;
    logic [255:0] ctx_asid;
    logic [127:0] ctx_sizeavail;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [1:0]   m_state;
    logic [31:0]  m_dsr;
    logic [63:0]  m_cbr;
    logic [255:0] m_asid;
    logic [127:0] m_size;

    always #5 clk = ~clk;

    ctx_cfg_unit #(.OP_LAT(OP_LAT)) dut_i (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_opc(cmd_opc),
        .req_dsr_map(req_dsr_map), .req_cbr_map(req_cbr_map),
        .req_asid(req_asid), .req_sizeavail(req_sizeavail),
        .peer_dsr_own(peer_dsr_own), .peer_cbr_own(peer_cbr_own),
        .hs_status(hs_status), .hs_state(hs_state), .hs_cause(hs_cause),
        .own_dsr_map(own_dsr_map), .own_cbr_map(own_cbr_map),
        .ctx_asid(ctx_asid), .ctx_sizeavail(ctx_sizeavail)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cause(input logic [2:0] opc, input logic [1:0] st,
                                             input logic [31:0] d, input logic [63:0] c);
        case (opc)
            3'd1: return (st == 2'd1 || st == 2'd3) ? 4'd0 : 4'd3;
            3'd2: begin
                if (st != 2'd0)                 return 4'd4;
                if (c == 64'd0)                 return 4'd8;
                if ((c & peer_cbr_own) != 0)    return 4'd10;
                if ((d & peer_dsr_own) != 0)    return 4'd11;
                return 4'd0;
            end
            3'd3, 3'd5: return (st == 2'd2) ? 4'd0 : 4'd6;
            3'd4: return (st == 2'd1 || st == 2'd3) ? 4'd0 : 4'd5;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [1:0] exp_next(input logic [2:0] opc, input logic [1:0] st);
        case (opc)
            3'd1: return 2'd2;
            3'd2: return 2'd1;
            3'd3, 3'd5: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // applies the model update for a completed command
    task automatic model_apply(input logic [2:0] opc, input logic [3:0] c,
                               input logic [31:0] d, input logic [63:0] cb,
                               input logic [255:0] a, input logic [127:0] s);
        if (c == 4'd0) begin
            if (opc == 3'd2) begin
                m_dsr = d; m_cbr = cb; m_asid = a; m_size = s;
            end
            if (opc == 3'd4) begin
                m_dsr = '0; m_cbr = '0;
            end
            m_state = exp_next(opc, m_state);
        end
    endtask

    task automatic wait_done(input string req, output int n);
        n = 1;
        while (hs_status == 2'd2 && n < 50) begin
            @(negedge clk);
            n++;
        end
        n--;
    endtask

    task automatic compare_all(input string req, input logic [1:0] e_stat,
                               input logic [3:0] e_cause);
        chk(req, "status", hs_status, e_stat);
        chk(req, "cause", hs_cause, e_cause);
        chk(req, "state", hs_state, m_state);
        chk(req, "own_dsr", own_dsr_map, m_dsr);
        chk(req, "own_cbr", own_cbr_map, m_cbr);
        chk(req, "asid", ctx_asid, m_asid);
        chk(req, "sizeavail", ctx_sizeavail, m_size);
    endtask

    task automatic issue(input string req, input logic [2:0] opc,
                         input logic [31:0] d, input logic [63:0] cb);
        int n;
        logic [3:0] c;
        logic [255:0] a;
        logic [127:0] s;
        a = rnd256();
        s = rnd256()[127:0];
        @(negedge clk);
        cmd_opc = opc; req_dsr_map = d; req_cbr_map = cb;
        req_asid = a; req_sizeavail = s; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        chk("R2", "status active", hs_status, 2'd2);
        wait_done(req, n);
        chk("R2", "active span", n, OP_LAT);
        c = exp_cause(opc, m_state, d, cb);
        model_apply(opc, c, d, cb, a, s);
        compare_all(req, (c == 4'd0) ? 2'd0 : 2'd1, c);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int n;
        logic [2:0] ro;
        logic [63:0] rc;
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        rst = 1'b1; cmd_go = 1'b0; cmd_opc = '0;
        req_dsr_map = '0; req_cbr_map = '0; req_asid = '0; req_sizeavail = '0;
        peer_dsr_own = 32'h0000_00F0; peer_cbr_own = 64'h0000_0000_0000_FF00;
        m_state = 2'd0; m_dsr = '0; m_cbr = '0; m_asid = '0; m_size = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        compare_all("R1", 2'd0, 4'd0);

        issue("R5", 3'd3, 32'h1, 64'h1);              // interrupt from inactive -> 6
        issue("R5", 3'd1, 32'h1, 64'h1);              // start from inactive -> 3
        issue("R5", 3'd4, 32'h1, 64'h1);              // dealloc from inactive -> 5
        issue("R6", 3'd6, 32'h1, 64'h1);
        issue("R6", 3'd0, 32'h1, 64'h1);
        issue("R6", 3'd7, 32'h1, 64'h1);
        issue("R7", 3'd2, 32'h10, 64'h0);             // zero cbr beats dsr conflict
        issue("R8", 3'd2, 32'h10, 64'h100);           // cbr and dsr conflict -> 10
        issue("R8", 3'd2, 32'h10, 64'h1);             // dsr conflict only -> 11
        issue("R3", 3'd2, 32'h0F, 64'h00FF_0000_0000_00FF);   // success, R10 idle again
        issue("R5", 3'd2, 32'h1, 64'h1);              // allocate from mapped -> 4
        issue("R4", 3'd1, 32'h0, 64'h0);              // mapped -> active
        issue("R5", 3'd1, 32'h0, 64'h0);              // start from active -> 3
        issue("R5", 3'd4, 32'h0, 64'h0);              // dealloc from active -> 5
        issue("R4", 3'd3, 32'h0, 64'h0);              // active -> interrupted
        issue("R5", 3'd5, 32'h0, 64'h0);              // intr-sync from interrupted -> 6
        issue("R4", 3'd1, 32'h0, 64'h0);              // interrupted -> active
        issue("R4", 3'd5, 32'h0, 64'h0);              // interrupt-sync -> interrupted
        issue("R4", 3'd4, 32'h0, 64'h0);              // dealloc clears maps

        // R9 busy: second strobe during active window
        begin
            logic [255:0] a;
            a = rnd256();
            @(negedge clk);
            cmd_opc = 3'd2; req_dsr_map = 32'h3; req_cbr_map = 64'h3;
            req_asid = a; req_sizeavail = 128'h5; cmd_go = 1'b1;
            @(negedge clk);
            cmd_opc = 3'd1; cmd_go = 1'b1;
            @(negedge clk);
            cmd_go = 1'b0;
            wait_done("R9", n);
            model_apply(3'd2, 4'd0, 32'h3, 64'h3, a, 128'h5);
            compare_all("R9", 2'd1, 4'd7);
            chk("R9", "span", n, OP_LAT - 1);
        end
        issue("R10", 3'd1, 32'h0, 64'h0);             // recovers to idle after exception

        // randomized mix against the model
        for (int i = 0; i < 120; i++) begin
            ro = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(1, 5)) : 3'($urandom_range(0, 7));
            rc = ($urandom_range(0, 7) == 0) ? 64'd0 : {$urandom, $urandom};
            rd = $urandom;
            if (m_state == 2'd0 && $urandom_range(0, 1) == 1) begin
                @(negedge clk);
                peer_cbr_own = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
                peer_dsr_own = $urandom & $urandom & $urandom;
            end
            issue("R4", ro, rd, rc & ~(($urandom_range(0, 1) == 1) ? peer_cbr_own : 64'd0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule